// File: doc/BRIEF.md
# Page-list scatter-gather walker

The walker turns one data transfer, described by a byte length and two 64-bit page pointers, into an ordered list of (address, length) segments for a DMA engine. The page size is chosen per walk as a power of two. The first pointer may start anywhere inside a page. The second pointer is either the one page that holds the rest of the data, or the address of a list of 64-bit page entries in host memory. A list can end in a link to a further list.

List entries are fetched one 64-bit word at a time through a read request/response port. The walker holds the segments in a small internal buffer until the whole walk has passed every validity rule. Only then does it stream them out on a valid/ready channel, with a last flag on the final segment. If any rule fails, the buffered segments are dropped and none leave the block. A single-cycle done pulse reports the outcome with a status code and a do-not-retry flag.

Top module: `sg_walker`

## Requirements
- R1: When the first pointer is zero, the walk ends with done, status 0x02 (invalid field) and done_dnr = 1. No segment is emitted and no read is issued.
- R2: The first segment has address ptr_a and length min(xfer_len, P - (ptr_a mod P)), where P = 2^pg_shift.
- R3: When the first segment covers the whole transfer, the walk ends with status 0x00 and done_dnr = 0. Exactly one segment is emitted, with last set. No read is issued, and ptr_b is not looked at (zero is fine).
- R4: When the remainder after the first segment is between 1 and P bytes, ptr_b is emitted directly as the final segment, with that remainder as its length, and no read is issued. In this case ptr_b must be nonzero and a multiple of P, otherwise the walk fails with 0x02 and dnr.
- R5: When the remainder exceeds P, ptr_b is the base of an entry list. A zero ptr_b fails the walk. Entry i is read by one request at address base + 8*i, and rd_rsp_data is taken as that 64-bit entry. Each entry yields a segment of min(remaining, P) bytes. No entry beyond the one that finishes the transfer is read.
- R6: A list holds P/8 entries. At the final slot of a list, the entry is used as a link when more than P bytes still remain: it becomes the new base, and reading resumes at index 0. If at most P bytes remain at that slot, the entry is ordinary data. A link must be nonzero and a multiple of P.
- R7: A data entry that is zero or not a multiple of P fails the walk with 0x02 and dnr, and no segment is emitted.
- R8: Segments leave only after a successful walk, in walk order, with seg_last on the final one only. While seg_valid is high and seg_ready is low, the segment fields hold still.
- R9: busy is high from the cycle after start is accepted until done. done is a single-cycle pulse, raised the cycle after the final segment handshake or the cycle after a violation is found. A start presented during the done cycle is accepted.
- R10: Once rd_req_valid rises, it stays high with a stable rd_req_addr until rd_req_ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (taken when not busy) |
| xfer_len | input | LEN_W | Transfer length in bytes |
| ptr_a | input | 64 | First page pointer, any byte offset |
| ptr_b | input | 64 | Second pointer: direct page or list base |
| pg_shift | input | SH_W | log2 of page size, PAGE_SHIFT_MIN..PAGE_SHIFT_MAX |
| busy | output | 1 | Walk in progress |
| rd_req_valid | output | 1 | List entry read request |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | 64 | Byte address of the 64-bit entry |
| rd_rsp_valid | input | 1 | Read data returned |
| rd_rsp_data | input | 64 | Entry value |
| seg_valid | output | 1 | Segment available |
| seg_ready | input | 1 | Segment consumed |
| seg_addr | output | 64 | Segment start address |
| seg_len | output | LEN_W | Segment length in bytes |
| seg_last | output | 1 | Final segment of the walk |
| done | output | 1 | One-cycle completion pulse |
| done_code | output | 8 | 0x00 success, 0x02 invalid field |
| done_dnr | output | 1 | Do-not-retry flag, set with an error |

## Verification
Two events can share one cycle: the done pulse that closes one walk, and the acceptance of the start that opens the next. The bench launches every new walk in the cycle where done is seen, so every pair of consecutive walks exercises this overlap. It then checks that busy is high on the following cycle and that the new walk's reads, segments and status match the scoreboard. Any result that leaks from the old walk into the new one, or any lost start, appears as a segment or status mismatch.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FIRST,
    ST_SECOND,
    ST_REQ,
    ST_WAIT,
    ST_DRAIN
  } walk_st_t;

  localparam logic [7:0] STAT_OK        = 8'h00;
  localparam logic [7:0] STAT_BAD_FIELD = 8'h02;
endpackage

// File: rtl/sgw_seg_buf.sv
module sgw_seg_buf #(
  parameter int ADDR_W = 64,
  parameter int LEN_W  = 16,
  parameter int PTR_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [LEN_W-1:0]  wr_len,
  input  logic              drain_go,
  output logic              drain_done,
  output logic              seg_valid,
  input  logic              seg_ready,
  output logic [ADDR_W-1:0] seg_addr,
  output logic [LEN_W-1:0]  seg_len,
  output logic              seg_last
);
  localparam int DEPTH = 1 << PTR_W;
  localparam logic [PTR_W:0] PTR_ONE = 1;

  logic [ADDR_W-1:0] mem_addr [DEPTH];
  logic [LEN_W-1:0]  mem_len  [DEPTH];
  logic [PTR_W:0]    wr_ptr, rd_ptr;
  logic              draining;
  logic              load;

  assign load       = draining && (rd_ptr != wr_ptr) && (!seg_valid || seg_ready);
  assign drain_done = seg_valid && seg_ready && seg_last;

  // write port: plain RAM write, no reset
  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_addr[wr_ptr[PTR_W-1:0]] <= wr_addr;
      mem_len[wr_ptr[PTR_W-1:0]]  <= wr_len;
    end
  end

  // registered read straight into the output fields
  always_ff @(posedge clk) begin
    if (load) begin
      seg_addr <= mem_addr[rd_ptr[PTR_W-1:0]];
      seg_len  <= mem_len[rd_ptr[PTR_W-1:0]];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      draining  <= 1'b0;
      seg_valid <= 1'b0;
      seg_last  <= 1'b0;
    end else if (clear) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      draining  <= 1'b0;
      seg_valid <= 1'b0;
      seg_last  <= 1'b0;
    end else begin
      if (wr_en)    wr_ptr   <= wr_ptr + PTR_ONE;
      if (drain_go) draining <= 1'b1;
      if (load) begin
        rd_ptr    <= rd_ptr + PTR_ONE;
        seg_valid <= 1'b1;
        seg_last  <= ((rd_ptr + PTR_ONE) == wr_ptr);
      end else if (seg_ready) begin
        seg_valid <= 1'b0;
      end
      if (drain_done) draining <= 1'b0;
    end
  end

  a_r8_hold_fields: assert property (@(posedge clk) disable iff (rst)
    (seg_valid && !seg_ready) |=> (seg_valid && $stable(seg_addr) &&
                                   $stable(seg_len) && $stable(seg_last)));
endmodule

// File: rtl/sgw_walk_fsm.sv
module sgw_walk_fsm
  import sgw_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int LEN_W  = 16,
  parameter int SH_W   = 5,
  parameter int IDX_W  = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [LEN_W-1:0]  xfer_len,
  input  logic [ADDR_W-1:0] ptr_a,
  input  logic [ADDR_W-1:0] ptr_b,
  input  logic [SH_W-1:0]   pg_shift,
  output logic              busy,
  output logic              in_drain,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  input  logic [ADDR_W-1:0] rd_rsp_data,
  output logic              clear,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [LEN_W-1:0]  wr_len,
  output logic              drain_go,
  input  logic              drain_done,
  output logic              done,
  output logic [7:0]        done_code,
  output logic              done_dnr
);
  localparam logic [ADDR_W-1:0] WORD_BYTES = 8;
  localparam logic [IDX_W-1:0]  IDX_ONE    = 1;

  walk_st_t          st;
  logic [LEN_W-1:0]  rem;
  logic [ADDR_W-1:0] p1, p2;
  logic [SH_W-1:0]   sh;
  logic [IDX_W-1:0]  idx;

  logic [ADDR_W-1:0] page_sz, pmask, room, rem_w, last_slot;
  logic [LEN_W-1:0]  first_len, chunk;
  logic              ent_bad, p2_bad, at_last_slot, rem_gt_page;

  assign page_sz      = ADDR_W'(1) << sh;
  assign pmask        = page_sz - ADDR_W'(1);
  assign room         = page_sz - (p1 & pmask);
  assign rem_w        = {{(ADDR_W-LEN_W){1'b0}}, rem};
  assign rem_gt_page  = rem_w > page_sz;
  assign first_len    = (rem_w < room) ? rem : LEN_W'(room);
  assign chunk        = rem_gt_page ? LEN_W'(page_sz) : rem;
  assign last_slot    = (page_sz >> 3) - ADDR_W'(1);
  assign at_last_slot = ({{(ADDR_W-IDX_W){1'b0}}, idx} == last_slot);
  assign ent_bad      = (rd_rsp_data == '0) || ((rd_rsp_data & pmask) != '0);
  assign p2_bad       = (p2 & pmask) != '0;

  assign busy         = (st != ST_IDLE);
  assign in_drain     = (st == ST_DRAIN);
  assign rd_req_valid = (st == ST_REQ);

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      rem         <= '0;
      p1          <= '0;
      p2          <= '0;
      sh          <= '0;
      idx         <= '0;
      rd_req_addr <= '0;
      wr_addr     <= '0;
      wr_len      <= '0;
      wr_en       <= 1'b0;
      clear       <= 1'b0;
      drain_go    <= 1'b0;
      done        <= 1'b0;
      done_code   <= STAT_OK;
      done_dnr    <= 1'b0;
    end else begin
      wr_en    <= 1'b0;
      clear    <= 1'b0;
      drain_go <= 1'b0;
      done     <= 1'b0;
      unique case (st)
        ST_IDLE: if (start) begin
          rem   <= xfer_len;
          p1    <= ptr_a;
          p2    <= ptr_b;
          sh    <= pg_shift;
          clear <= 1'b1;
          st    <= ST_FIRST;
        end
        ST_FIRST: begin
          if (p1 == '0) begin
            done <= 1'b1; done_code <= STAT_BAD_FIELD; done_dnr <= 1'b1;
            st   <= ST_IDLE;
          end else begin
            wr_en   <= 1'b1;
            wr_addr <= p1;
            wr_len  <= first_len;
            rem     <= rem - first_len;
            st      <= ST_SECOND;
          end
        end
        ST_SECOND: begin
          if (rem == '0) begin
            drain_go <= 1'b1;
            st       <= ST_DRAIN;
          end else if ((p2 == '0) || (!rem_gt_page && p2_bad)) begin
            done <= 1'b1; done_code <= STAT_BAD_FIELD; done_dnr <= 1'b1;
            st   <= ST_IDLE;
          end else if (!rem_gt_page) begin
            wr_en    <= 1'b1;
            wr_addr  <= p2;
            wr_len   <= rem;
            rem      <= '0;
            drain_go <= 1'b1;
            st       <= ST_DRAIN;
          end else begin
            rd_req_addr <= p2;
            idx         <= '0;
            st          <= ST_REQ;
          end
        end
        ST_REQ: if (rd_req_ready) st <= ST_WAIT;
        ST_WAIT: if (rd_rsp_valid) begin
          if (ent_bad) begin
            done <= 1'b1; done_code <= STAT_BAD_FIELD; done_dnr <= 1'b1;
            st   <= ST_IDLE;
          end else if (at_last_slot && rem_gt_page) begin
            rd_req_addr <= rd_rsp_data;
            idx         <= '0;
            st          <= ST_REQ;
          end else begin
            wr_en       <= 1'b1;
            wr_addr     <= rd_rsp_data;
            wr_len      <= chunk;
            rem         <= rem - chunk;
            idx         <= idx + IDX_ONE;
            rd_req_addr <= rd_req_addr + WORD_BYTES;
            if (rem == chunk) begin
              drain_go <= 1'b1;
              st       <= ST_DRAIN;
            end else begin
              st <= ST_REQ;
            end
          end
        end
        ST_DRAIN: if (drain_done) begin
          done <= 1'b1; done_code <= STAT_OK; done_dnr <= 1'b0;
          st   <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  a_r1_null_first: assert property (@(posedge clk) disable iff (rst)
    (st == ST_FIRST && p1 == '0) |=> (done && done_dnr && st == ST_IDLE));
  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r10_req_hold: assert property (@(posedge clk) disable iff (rst)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));
endmodule

// File: rtl/sg_walker.sv
module sg_walker #(
  parameter int LEN_W          = 16,
  parameter int PAGE_SHIFT_MIN = 12,
  parameter int PAGE_SHIFT_MAX = 16,
  localparam int SH_W          = $clog2(PAGE_SHIFT_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [LEN_W-1:0]  xfer_len,
  input  logic [63:0]       ptr_a,
  input  logic [63:0]       ptr_b,
  input  logic [SH_W-1:0]   pg_shift,
  output logic              busy,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [63:0]       rd_req_addr,
  input  logic              rd_rsp_valid,
  input  logic [63:0]       rd_rsp_data,
  output logic              seg_valid,
  input  logic              seg_ready,
  output logic [63:0]       seg_addr,
  output logic [LEN_W-1:0]  seg_len,
  output logic              seg_last,
  output logic              done,
  output logic [7:0]        done_code,
  output logic              done_dnr
);
  localparam int ADDR_W   = 64;
  localparam int MAX_SEGS = ((1 << LEN_W) - 1) / (1 << PAGE_SHIFT_MIN) + 2;
  localparam int PTR_W    = $clog2(MAX_SEGS);
  localparam int IDX_W    = PAGE_SHIFT_MAX - 2;

  logic              clear, wr_en, drain_go, drain_done, in_drain;
  logic [ADDR_W-1:0] wr_addr;
  logic [LEN_W-1:0]  wr_len;

  sgw_walk_fsm #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .SH_W(SH_W), .IDX_W(IDX_W)
  ) u_fsm (
    .clk(clk), .rst(rst), .start(start), .xfer_len(xfer_len),
    .ptr_a(ptr_a), .ptr_b(ptr_b), .pg_shift(pg_shift),
    .busy(busy), .in_drain(in_drain),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_req_addr(rd_req_addr), .rd_rsp_valid(rd_rsp_valid),
    .rd_rsp_data(rd_rsp_data),
    .clear(clear), .wr_en(wr_en), .wr_addr(wr_addr), .wr_len(wr_len),
    .drain_go(drain_go), .drain_done(drain_done),
    .done(done), .done_code(done_code), .done_dnr(done_dnr)
  );

  sgw_seg_buf #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PTR_W(PTR_W)
  ) u_buf (
    .clk(clk), .rst(rst), .clear(clear),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_len(wr_len),
    .drain_go(drain_go), .drain_done(drain_done),
    .seg_valid(seg_valid), .seg_ready(seg_ready),
    .seg_addr(seg_addr), .seg_len(seg_len), .seg_last(seg_last)
  );

  a_r8_seg_in_drain: assert property (@(posedge clk) disable iff (rst)
    seg_valid |-> in_drain);
endmodule

// File: tb/test_sg_walker.sv
`timescale 1ns/1ps
module test_sg_walker;
  localparam int LW = 12;

  logic clk = 0, rst = 1, start = 0;
  logic [LW-1:0] xfer_len = '0;
  logic [63:0] ptr_a = '0, ptr_b = '0;
  logic [3:0]  pg_shift = '0;
  logic busy, rd_req_valid, rd_req_ready = 0, rd_rsp_valid = 0;
  logic [63:0] rd_req_addr, rd_rsp_data = '0;
  logic seg_valid, seg_ready = 0, seg_last, done, done_dnr;
  logic [63:0] seg_addr;
  logic [LW-1:0] seg_len;
  logic [7:0] done_code;

  sg_walker #(.LEN_W(LW), .PAGE_SHIFT_MIN(6), .PAGE_SHIFT_MAX(12)) i_sg_walker (
    .clk(clk), .rst(rst), .start(start), .xfer_len(xfer_len),
    .ptr_a(ptr_a), .ptr_b(ptr_b), .pg_shift(pg_shift), .busy(busy),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_req_addr(rd_req_addr), .rd_rsp_valid(rd_rsp_valid),
    .rd_rsp_data(rd_rsp_data), .seg_valid(seg_valid), .seg_ready(seg_ready),
    .seg_addr(seg_addr), .seg_len(seg_len), .seg_last(seg_last),
    .done(done), .done_code(done_code), .done_dnr(done_dnr));

  always #2.5 clk = ~clk;

  int n_chk = 0, n_err = 0;
  bit finished = 0;
  string cur_tag = "";
  bit ready_all = 1;
  logic [15:0] lfsr = 16'hACE1;

  logic [63:0] hmem [logic [63:0]];
  logic [63:0] exp_a[$], exp_rd[$];
  int          exp_l[$];
  bit          exp_last[$], exp_err[$];

  bit pend = 0; int rsp_cnt = 0; logic [63:0] pend_addr;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mem_rd(input logic [63:0] a);
    return hmem.exists(a) ? hmem[a] : 64'd0;
  endfunction

  // expectation from the requirements
  task automatic model(input int len, input logic [63:0] p1, input logic [63:0] p2, input int sh);
    logic [63:0] pg, base, e, a, qa[$];
    int ql[$]; int rem, f, i, epl, c; bit bad;
    pg = 64'd1 << sh; epl = int'(pg >> 3); bad = 0;
    if (p1 == 0) bad = 1;
    else begin
      f = int'(pg - (p1 % pg)); if (len < f) f = len;
      qa.push_back(p1); ql.push_back(f); rem = len - f;
      if (rem != 0) begin
        if (p2 == 0) bad = 1;
        else if (64'(rem) <= pg) begin
          if (p2 % pg != 0) bad = 1;
          else begin qa.push_back(p2); ql.push_back(rem); end
        end else begin
          base = p2; i = 0;
          while (rem > 0 && !bad) begin
            a = base + 64'(i * 8); exp_rd.push_back(a); e = mem_rd(a);
            if (e == 0 || e % pg != 0) bad = 1;
            else if (i == epl - 1 && 64'(rem) > pg) begin base = e; i = 0; end
            else begin
              c = (64'(rem) > pg) ? int'(pg) : rem;
              qa.push_back(e); ql.push_back(c); rem -= c; i++;
            end
          end
        end
      end
    end
    exp_err.push_back(bad);
    if (!bad)
      for (int k = 0; k < qa.size(); k++) begin
        exp_a.push_back(qa[k]); exp_l.push_back(ql[k]); exp_last.push_back(k == qa.size() - 1);
      end
  endtask

  task automatic run_walk(input string tag, input int len, input logic [63:0] p1,
                          input logic [63:0] p2, input int sh, input bit rdy);
    cur_tag = tag; ready_all = rdy;
    model(len, p1, p2, sh);
    xfer_len = LW'(len); ptr_a = p1; ptr_b = p2; pg_shift = 4'(sh); start = 1;
    @(posedge clk); #1; start = 0;
    @(negedge clk);
    chk(busy == 1, {tag, " R9 busy after start"}, 64'(busy), 1);
    while (!done) @(negedge clk);
    #1;
  endtask

  // input drivers, just after the rising edge
  initial begin
    forever begin
      @(posedge clk); #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      seg_ready    = ready_all ? 1'b1 : lfsr[0];
      rd_req_ready = lfsr[1] | lfsr[2];
      rd_rsp_valid = 0;
      if (pend) begin
        if (rsp_cnt == 0) begin
          rd_rsp_valid = 1; rd_rsp_data = mem_rd(pend_addr); pend = 0;
        end else rsp_cnt--;
      end
    end
  end

  // monitor / scoreboard, on the falling edge
  bit st_seg = 0, st_rd = 0;
  logic [63:0] st_a, st_ra; logic [LW-1:0] st_l; logic st_last;
  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (st_seg)
          chk(seg_valid && seg_addr == st_a && seg_len == st_l && seg_last == st_last,
              "R8 stall hold", seg_addr, st_a);
        if (st_rd)
          chk(rd_req_valid && rd_req_addr == st_ra, "R10 request hold", rd_req_addr, st_ra);
        st_seg = seg_valid && !seg_ready; st_a = seg_addr; st_l = seg_len; st_last = seg_last;
        st_rd = rd_req_valid && !rd_req_ready; st_ra = rd_req_addr;
        if (seg_valid && seg_ready) begin
          if (exp_a.size() == 0) chk(0, {cur_tag, " R8 unexpected segment"}, seg_addr, 0);
          else begin
            logic [63:0] ea; int el; bit elast;
            ea = exp_a.pop_front(); el = exp_l.pop_front(); elast = exp_last.pop_front();
            chk(seg_addr == ea, {cur_tag, " seg addr"}, seg_addr, ea);
            chk(int'(seg_len) == el && seg_last == elast, {cur_tag, " R8 seg len/last"},
                {seg_last, 51'd0, seg_len}, {elast, 51'd0, 12'(el)});
          end
        end
        if (rd_req_valid && rd_req_ready) begin
          if (exp_rd.size() == 0) chk(0, {cur_tag, " R5 unexpected read"}, rd_req_addr, 0);
          else begin
            logic [63:0] er; er = exp_rd.pop_front();
            chk(rd_req_addr == er, {cur_tag, " R5 read addr"}, rd_req_addr, er);
          end
          pend = 1; pend_addr = rd_req_addr; rsp_cnt = lfsr[3] ? 1 : 0;
        end
        if (done) begin
          bit ee; ee = exp_err.size() ? exp_err.pop_front() : 0;
          chk(done_code == (ee ? 8'h02 : 8'h00) && done_dnr == ee, {cur_tag, " status"},
              {done_dnr, done_code}, {ee, (ee ? 8'h02 : 8'h00)});
          chk(exp_a.size() == 0 && exp_rd.size() == 0, {cur_tag, " R8 R5 all items seen"},
              64'(exp_a.size() + exp_rd.size()), 0);
        end
      end
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog R9 actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk); #1; rst = 0;
    @(negedge clk);
    chk(!busy && !seg_valid && !done && !rd_req_valid, "R9 reset state",
        {busy, seg_valid, done, rd_req_valid}, 0);
    #1;
    run_walk("R1 null first", 100, 64'h0, 64'h2000, 6, 1);
    run_walk("R2 R3 single", 40, 64'h1010, 64'h0, 6, 1);
    run_walk("R4 direct", 100, 64'h1010, 64'h2000, 6, 0);
    run_walk("R4 direct misaligned", 100, 64'h1010, 64'h2004, 6, 1);
    run_walk("R4 direct zero", 100, 64'h1010, 64'h0, 6, 1);
    for (int i = 0; i < 4; i++) hmem[64'h3000 + 64'(8 * i)] = 64'h4000 + 64'(i * 64'h1000);
    run_walk("R5 list", 300, 64'h1000, 64'h3000, 6, 0);
    run_walk("R5 list base zero", 300, 64'h1000, 64'h0, 6, 1);
    hmem[64'h3010] = 64'h5008;
    run_walk("R7 bad entry", 300, 64'h1000, 64'h3000, 6, 1);
    hmem.delete();
    for (int i = 0; i < 7; i++) hmem[64'h3000 + 64'(8 * i)] = 64'h8000 + 64'(i * 64);
    hmem[64'h3038] = 64'h3800;
    for (int i = 0; i < 4; i++) hmem[64'h3800 + 64'(8 * i)] = 64'h9000 + 64'(i * 64);
    run_walk("R6 chained", 768, 64'h1000, 64'h3000, 6, 0);
    hmem[64'h3038] = 64'hA000;
    run_walk("R6 last slot data", 576, 64'h1000, 64'h3000, 6, 1);
    hmem[64'h3038] = 64'h0;
    run_walk("R6 link zero", 768, 64'h1000, 64'h3000, 6, 1);
    hmem.delete();
    for (int i = 0; i < 4; i++) hmem[64'h3000 + 64'(8 * i)] = 64'h20000 + 64'(i * 256);
    run_walk("R2 R5 page256", 1000, 64'h10F0, 64'h3000, 8, 0);
    run_walk("R9 back to back", 40, 64'h1010, 64'h0, 6, 0);
    repeat (3) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule